// File: doc/BRIEF.md
# PWM High-Time and Duty Meter

This block measures a slow pulse-width-modulated input against a free-running timer. A 16-bit counter runs from one of four selectable tick sources. The input is synchronised, and its edges are detected on the synchronised copy. The first rising edge stores a timer snapshot, and the capture logic then waits for the falling edge. At the falling edge the block subtracts the two snapshots modulo 2^16 to get the high time in ticks. It divides that count by a programmed period count to form an 8-bit duty code.

Results leave through a valid/ready output. The meter cannot slow the signal it watches, so back-pressure never stalls measurement. A result that is not taken is held stable until `meas_ready` is seen. If a newer measurement completes first, it replaces the held one. With `meas_ready` tied high, `meas_valid` is a one-clock done pulse per measured high phase.

A programmable watchdog flags an input that stops toggling. While that flag is raised, the duty output shows 0% or 100% according to the stuck level.

Top module: `pwm_width_meter`

## Requirements
- R1: After reset `meas_valid`, `stuck`, `meas_high` and `meas_duty` are all zero.
- R2: `clk_src_sel` picks the timer tick: 0 = every 12th clock, 1 = every 2nd clock, 2 = every clock on which `ovf_tick` is high, 3 = every synchronised rising edge of `ext_cnt`.
- R3: Capture is armed for a rising edge first and for a falling edge after that. A falling edge seen while armed for a rising edge yields no result.
- R4: `meas_high` equals the number of timer ticks between the rising and falling captures. The count is an unsigned 16-bit difference, so it stays correct when the timer wraps inside a high phase.
- R5: `meas_duty` = min(255, floor(`meas_high` × 255 / `period_cnt`)). A `period_cnt` of 0 gives 0.
- R6: A result raises `meas_valid` three clocks after the input's falling edge. `meas_valid` and the data stay stable until a cycle with `meas_ready` high, after which `meas_valid` drops. A newer result overwrites an unaccepted one.
- R7: With `stuck_limit` nonzero, the absence of any input edge for `stuck_limit` clocks sets `stuck`. It also forces `meas_duty` to 255 if the input is high or 0 if it is low, and re-arms capture for a rising edge. The next input edge clears `stuck`. A `stuck_limit` of 0 disables the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_src_sel | input | 2 | Timer tick source select (R2 encoding) |
| ovf_tick | input | 1 | External synchronous tick enable (source 2) |
| ext_cnt | input | 1 | Asynchronous external count input (source 3) |
| pwm_in | input | 1 | Asynchronous PWM input to measure |
| period_cnt | input | 16 | Timer ticks in one nominal input period |
| stuck_limit | input | 16 | Watchdog limit in clocks, 0 disables |
| meas_valid | output | 1 | Result valid |
| meas_ready | input | 1 | Result accepted by the consumer |
| meas_high | output | 16 | High time in timer ticks |
| meas_duty | output | 8 | Duty code, 255 = full period |
| stuck | output | 1 | Input has stopped toggling |

## Verification
High phases are timed with each of the four tick sources. Matching the tick counts shows that the sources are decoded correctly and that the snapshots are taken at matching points of the two edges.

Duty codes are checked at several points:
- near 5%, 50% and 95%;
- above one full period, which shows saturation;
- with a zero period.

These checks separate rounding errors from range errors. A run of repeated pulses sweeps the timer through its rollover, which exposes a subtraction that fails to wrap. A stalled high input followed by a stalled low one shows the forced codes. The same run shows that a falling edge arriving after the watchdog re-armed capture produces no result. A held, then overwritten, result shows the back-pressure rule.

// File: rtl/pwm_meter_pkg.sv
package pwm_meter_pkg;
  typedef enum logic [1:0] {
    SRC_SLOW = 2'd0,
    SRC_FAST = 2'd1,
    SRC_TICK = 2'd2,
    SRC_EXT  = 2'd3
  } tick_src_e;

  typedef enum logic {
    ARM_RISE = 1'b0,
    ARM_FALL = 1'b1
  } arm_e;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_meter_pkg::*;
#(
  parameter int TMR_W    = 16,
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       src_sel,
  input  logic             ovf_tick,
  input  logic             ext_cnt,
  output logic [TMR_W-1:0] timer
);
  localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int PS_W    = $clog2(DIV_MAX + 1);

  logic [PS_W-1:0] ps_cnt;
  logic [PS_W-1:0] ps_last;
  logic            ps_wrap;
  logic [2:0]      ext_sh;
  logic            ext_rise;
  logic            tick;
  tick_src_e       src;

  assign src      = tick_src_e'(src_sel);
  assign ps_last  = (src == SRC_SLOW) ? PS_W'(DIV_SLOW - 1) : PS_W'(DIV_FAST - 1);
  assign ps_wrap  = (ps_cnt >= ps_last);
  assign ext_rise = ext_sh[1] & ~ext_sh[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps_cnt <= '0;
      ext_sh <= '0;
    end else begin
      ext_sh <= {ext_sh[1:0], ext_cnt};
      ps_cnt <= ps_wrap ? '0 : ps_cnt + 1'b1;
    end
  end

  always_comb begin
    unique case (src)
      SRC_SLOW, SRC_FAST: tick = ps_wrap;
      SRC_TICK:           tick = ovf_tick;
      SRC_EXT:            tick = ext_rise;
      default:            tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    timer <= '0;
    else if (tick) timer <= timer + 1'b1;
  end

  // R4
  timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(timer) |-> timer == TMR_W'($past(timer) + 1'b1));
endmodule

// File: rtl/pwm_edge_capture.sv
module pwm_edge_capture
  import pwm_meter_pkg::*;
#(
  parameter int TMR_W = 16,
  parameter int LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  input  logic [TMR_W-1:0] timer,
  input  logic [LIM_W-1:0] stuck_limit,
  output logic             cap_done,
  output logic [TMR_W-1:0] high_cnt,
  output logic             stuck,
  output logic             stuck_set,
  output logic             level
);
  logic [2:0]       sync_sh;
  logic             rise, fall;
  arm_e             arm;
  logic [TMR_W-1:0] snap_rise;
  logic [LIM_W-1:0] idle_cnt;
  logic             hit;

  assign level    = sync_sh[1];
  assign rise     = sync_sh[1] & ~sync_sh[2];
  assign fall     = ~sync_sh[1] & sync_sh[2];
  assign cap_done = fall && (arm == ARM_FALL);
  assign high_cnt = timer - snap_rise;
  assign hit      = (stuck_limit != '0) && !stuck && !rise && !fall &&
                    (idle_cnt == stuck_limit - 1'b1);
  assign stuck_set = hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_sh   <= '0;
      arm       <= ARM_RISE;
      snap_rise <= '0;
    end else begin
      sync_sh <= {sync_sh[1:0], pwm_in};
      if (hit) begin
        arm <= ARM_RISE;
      end else if (arm == ARM_RISE && rise) begin
        snap_rise <= timer;
        arm       <= ARM_FALL;
      end else if (cap_done) begin
        arm <= ARM_RISE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      stuck    <= 1'b0;
    end else if (rise || fall || stuck_limit == '0) begin
      idle_cnt <= '0;
      stuck    <= 1'b0;
    end else if (hit) begin
      stuck <= 1'b1;
    end else if (!stuck) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  // R3
  rearm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |=> arm == ARM_RISE);
  // R7
  stuck_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stuck && (rise || fall)) |=> !stuck);
endmodule

// File: rtl/pwm_duty_scaler.sv
module pwm_duty_scaler #(
  parameter int TMR_W  = 16,
  parameter int DUTY_W = 8
) (
  input  logic [TMR_W-1:0]  high_cnt,
  input  logic [TMR_W-1:0]  period_cnt,
  output logic [DUTY_W-1:0] duty
);
  localparam int PROD_W   = TMR_W + DUTY_W;
  localparam int FULL     = (1 << DUTY_W) - 1;

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quot;

  assign prod = PROD_W'(high_cnt) * PROD_W'(FULL);

  always_comb begin
    quot = '0;
    if (period_cnt != '0) quot = prod / PROD_W'(period_cnt);
  end

  assign duty = (quot > PROD_W'(FULL)) ? DUTY_W'(FULL) : quot[DUTY_W-1:0];
endmodule

// File: rtl/pwm_width_meter.sv
module pwm_width_meter
  import pwm_meter_pkg::*;
#(
  parameter int TMR_W    = 16,
  parameter int DUTY_W   = 8,
  parameter int LIM_W    = 16,
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        clk_src_sel,
  input  logic              ovf_tick,
  input  logic              ext_cnt,
  input  logic              pwm_in,
  input  logic [TMR_W-1:0]  period_cnt,
  input  logic [LIM_W-1:0]  stuck_limit,
  output logic              meas_valid,
  input  logic              meas_ready,
  output logic [TMR_W-1:0]  meas_high,
  output logic [DUTY_W-1:0] meas_duty,
  output logic              stuck
);
  logic [TMR_W-1:0]  timer;
  logic              cap_done;
  logic [TMR_W-1:0]  high_cnt;
  logic              stuck_set;
  logic              level;
  logic [DUTY_W-1:0] duty_new;

  pwm_timebase #(.TMR_W(TMR_W), .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_tb (
    .clk(clk), .rst_n(rst_n), .src_sel(clk_src_sel), .ovf_tick(ovf_tick),
    .ext_cnt(ext_cnt), .timer(timer));

  pwm_edge_capture #(.TMR_W(TMR_W), .LIM_W(LIM_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .timer(timer),
    .stuck_limit(stuck_limit), .cap_done(cap_done), .high_cnt(high_cnt),
    .stuck(stuck), .stuck_set(stuck_set), .level(level));

  pwm_duty_scaler #(.TMR_W(TMR_W), .DUTY_W(DUTY_W)) u_scl (
    .high_cnt(high_cnt), .period_cnt(period_cnt), .duty(duty_new));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meas_valid <= 1'b0;
      meas_high  <= '0;
      meas_duty  <= '0;
    end else begin
      if (cap_done) begin
        meas_valid <= 1'b1;
        meas_high  <= high_cnt;
        meas_duty  <= duty_new;
      end else begin
        if (meas_valid && meas_ready) meas_valid <= 1'b0;
        if (stuck_set) meas_duty <= level ? '1 : '0;
      end
    end
  end

  // R6
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid && !meas_ready) |=> meas_valid);
  // R6
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid && !meas_ready && !cap_done) |=> $stable(meas_high));
  // R7
  stuck_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stuck) |-> (meas_duty == '0 || meas_duty == '1));
endmodule

// File: tb/test_pwm_width_meter.sv
module test_pwm_width_meter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  clk_src_sel = 2'd2;
  logic        ovf_tick = 1'b1;
  logic        ext_cnt = 1'b0;
  logic        pwm_in = 1'b0;
  logic [15:0] period_cnt = 16'd1000;
  logic [15:0] stuck_limit = 16'd0;
  logic        meas_valid;
  logic        meas_ready = 1'b1;
  logic [15:0] meas_high;
  logic [7:0]  meas_duty;
  logic        stuck;

  int checks = 0;
  int fails  = 0;
  int res_cnt = 0;
  int last_high = 0;
  int last_duty = 0;
  bit ext_run = 1'b0;
  int ext_ph = 0;

  always #2 clk = ~clk;

  pwm_width_meter i_pwm_width_meter (
    .clk(clk), .rst_n(rst_n), .clk_src_sel(clk_src_sel), .ovf_tick(ovf_tick),
    .ext_cnt(ext_cnt), .pwm_in(pwm_in), .period_cnt(period_cnt),
    .stuck_limit(stuck_limit), .meas_valid(meas_valid), .meas_ready(meas_ready),
    .meas_high(meas_high), .meas_duty(meas_duty), .stuck(stuck));

  always @(negedge clk) begin
    if (meas_valid && meas_ready) begin
      res_cnt   <= res_cnt + 1;
      last_high <= int'(meas_high);
      last_duty <= int'(meas_duty);
    end
    if (ext_run) begin
      ext_ph  <= ext_ph + 1;
      if (ext_ph % 2 == 1) ext_cnt <= ~ext_cnt;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int hi, int lo);
    @(negedge clk);
    pwm_in = 1'b1;
    idle(hi);
    pwm_in = 1'b0;
    idle(lo);
  endtask

  function automatic int duty_of(int h, int p);
    int q;
    if (p == 0) return 0;
    q = (h * 255) / p;
    return (q > 255) ? 255 : q;
  endfunction

  task automatic t_reset();
    chk("R1 valid", int'(meas_valid), 0);
    chk("R1 stuck", int'(stuck), 0);
    chk("R1 high", int'(meas_high), 0);
    chk("R1 duty", int'(meas_duty), 0);
  endtask

  task automatic t_tick_duty();
    int hs[4] = '{500, 50, 950, 1200};
    clk_src_sel = 2'd2; ovf_tick = 1'b1; period_cnt = 16'd1000;
    foreach (hs[i]) begin
      pulse(hs[i], 30);
      chk("R4 tick high", last_high, hs[i]);
      chk("R5 duty", last_duty, duty_of(hs[i], 1000));
    end
    period_cnt = 16'd0;
    pulse(300, 30);
    chk("R5 zero period", last_duty, 0);
    period_cnt = 16'd1000;
  endtask

  task automatic t_prescale();
    int n;
    clk_src_sel = 2'd0; period_cnt = 16'd200;
    pulse(1200, 40);
    chk("R2 slow high", last_high, 100);
    chk("R5 slow duty", last_duty, duty_of(100, 200));
    clk_src_sel = 2'd1; period_cnt = 16'd600;
    pulse(600, 40);
    chk("R2 fast high", last_high, 300);
    chk("R5 fast duty", last_duty, duty_of(300, 600));
    clk_src_sel = 2'd2; ovf_tick = 1'b0;
    n = res_cnt;
    pulse(400, 40);
    chk("R2 tick gated", last_high, 0);
    chk("R6 result count", res_cnt, n + 1);
    ovf_tick = 1'b1;
    clk_src_sel = 2'd3; period_cnt = 16'd400; ext_run = 1'b1;
    idle(8);
    pulse(400, 40);
    chk("R2 ext high", last_high, 100);
    chk("R5 ext duty", last_duty, duty_of(100, 400));
    ext_run = 1'b0;
    clk_src_sel = 2'd2; period_cnt = 16'd1000;
  endtask

  task automatic t_wrap();
    int bad = 0;
    for (int k = 0; k < 12; k++) begin
      pulse(3000, 3000);
      if (last_high != 3000) bad++;
    end
    chk("R4 wrap sweep mismatches", bad, 0);
  endtask

  task automatic t_backpressure();
    int n;
    meas_ready = 1'b0;
    n = res_cnt;
    @(negedge clk); pwm_in = 1'b1; idle(200); pwm_in = 1'b0;
    idle(2);
    chk("R6 not before 3 clocks", int'(meas_valid), 0);
    idle(1);
    chk("R6 valid at 3 clocks", int'(meas_valid), 1);
    idle(20);
    chk("R6 held high", int'(meas_high), 200);
    chk("R6 held valid", int'(meas_valid), 1);
    pulse(300, 20);
    chk("R6 overwrite", int'(meas_high), 300);
    meas_ready = 1'b1;
    idle(2);
    chk("R6 accepted once", res_cnt, n + 1);
    chk("R6 valid dropped", int'(meas_valid), 0);
  endtask

  task automatic t_stuck();
    int n;
    stuck_limit = 16'd100;
    n = res_cnt;
    @(negedge clk); pwm_in = 1'b1;
    idle(50);
    chk("R7 not yet stuck", int'(stuck), 0);
    idle(150);
    chk("R7 stuck high", int'(stuck), 1);
    chk("R7 forced full", int'(meas_duty), 255);
    pwm_in = 1'b0;
    idle(10);
    chk("R7 cleared by edge", int'(stuck), 0);
    chk("R3 fall after rearm ignored", res_cnt, n);
    idle(200);
    chk("R7 stuck low", int'(stuck), 1);
    chk("R7 forced zero", int'(meas_duty), 0);
    stuck_limit = 16'd0;
    idle(5);
    chk("R7 disabled", int'(stuck), 0);
    pulse(500, 30);
    chk("R3 recovers", last_high, 500);
  endtask

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_tick_duty();
    t_prescale();
    t_backpressure();
    t_stuck();
    t_wrap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule